// File: doc/BRIEF.md
# Group-Wise Vector-Inserting Pattern Generator

This block feeds a circuit under test with one input vector per clock for low-power built-in self-test. A linear feedback shift register produces a sequence of pseudorandom base patterns. The block does not jump from one base pattern to the next in a single clock. Instead it walks across the transition group by group, so each applied vector differs from the one before it only inside one group of adjacent inputs. This lowers the peak number of input toggles seen by the circuit under test.

The groups are set by a boundary mask loaded at run time. A 1 in bit i closes a group at input i. The number of groups is therefore the number of ones in the mask, and an outside optimiser can tune both the group boundaries and the group count. Bit 0 is the first input. Groups are updated from the lowest input upward. When the top group has been copied, the applied vector equals the next register pattern. That pattern becomes the new base, and a one-clock strobe marks it.

The controller has two states. ST_BASE means the output holds a complete base pattern. ST_MID means a transition is partly done. The transitions are:
- ST_BASE to ST_MID: an enabled step that updated a group other than the top one.
- ST_BASE to ST_BASE: the generator is idle, a seed is loaded, or the mask holds a single group.
- ST_MID to ST_MID: a further step that is not the last, or a pause with enable low.
- ST_MID to ST_BASE: the step that copies the top group, or a seed load, which aborts the transition.

Top module: `gvi_pattern_gen`

## Requirements
- R1: After reset the output equals parameter SEED, `base_stb` is 0, the controller is in ST_BASE, and the mask is all ones, so every input is its own group.
- R2: A clock with `seed_ld` high makes both the output and the base pattern equal `seed_in` after that edge, and sends the controller to ST_BASE. This takes priority over `en` and aborts any transition in progress.
- R3: The next base pattern is `{base[W-2:0], ^(base & TAPS)}`, where TAPS bit k stands for feedback tap k+1.
- R4: Each clock with `en` high and `seed_ld` low copies the next-pattern bits into exactly one group: the lowest group not yet updated. All other output bits keep their values.
- R5: A transition takes exactly as many enabled clocks as there are ones in the effective mask. After the last of them the output equals the next base pattern.
- R6: Mask bit W-1 is treated as 1 whatever value was loaded, so the top input always closes a group.
- R7: `mask_ld` is accepted only in ST_BASE on a clock with no step. A load in ST_MID, or on a stepping clock, is ignored, so the mask never changes inside a transition.
- R8: While `en` and `seed_ld` are low, the output and the progress through the transition hold still.
- R9: `base_stb` is high for one clock right after each edge that completes a transition, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance one group per clock |
| seed_ld | input | 1 | Load `seed_in` as base and output |
| seed_in | input | W | Seed value |
| mask_ld | input | 1 | Request to load the boundary mask |
| mask_in | input | W | Boundary mask, 1 means the last input of a group |
| vec_out | output | W | Vector applied to the circuit under test |
| base_stb | output | 1 | One-clock pulse when a new base pattern is reached |

## Verification
A wrong group pointer or a wrong mask register shows up on `vec_out` at the very next enabled step, as bits that change outside the expected group. A wrong register feedback shows up as a wrong final vector at the end of the current transition. A stuck or wrong strobe, or a miscount of steps, appears on `base_stb` within one transition. The bench sweeps every 8-bit mask across a chain of transitions and compares each applied vector with an arithmetic model, so such faults are seen within a few clocks.

// File: rtl/gvi_pkg.sv
package gvi_pkg;
    typedef enum logic {
        ST_BASE = 1'b0,
        ST_MID  = 1'b1
    } gvi_state_t;
endpackage

// File: rtl/gvi_lfsr_step.sv
module gvi_lfsr_step #(
    parameter int          W    = 36,
    parameter logic [W-1:0] TAPS = '1
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    // R3: shift up, feedback is parity of tapped bits
    assign nxt = {cur[W-2:0], ^(cur & TAPS)};
endmodule

// File: rtl/gvi_group_sel.sv
module gvi_group_sel #(
    parameter int W  = 36,
    parameter int PW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  bound,
    input  logic [PW-1:0] ptr,
    output logic [W-1:0]  grp,
    output logic [PW-1:0] nptr,
    output logic          last
);
    logic open;

    always_comb begin
        open = 1'b1;
        grp  = '0;
        nptr = '0;
        for (int i = 0; i < W; i++) begin
            if ((i >= int'(ptr)) && open) begin
                grp[i] = 1'b1;
                if (bound[i]) begin
                    open = 1'b0;
                    nptr = PW'(i + 1);
                end
            end
        end
    end

    assign last = grp[W-1];
endmodule

// File: rtl/gvi_pattern_gen.sv
module gvi_pattern_gen
    import gvi_pkg::*;
#(
    parameter int           W    = 36,
    parameter logic [W-1:0] TAPS = 36'h801000000,
    parameter logic [W-1:0] SEED = 36'hf101bb288
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         seed_ld,
    input  logic [W-1:0] seed_in,
    input  logic         mask_ld,
    input  logic [W-1:0] mask_in,
    output logic [W-1:0] vec_out,
    output logic         base_stb
);
    localparam int PW = (W > 1) ? $clog2(W) : 1;

    gvi_state_t    st_q, st_n;
    logic [W-1:0]  base_q, vec_q, mask_q, eff_mask, nxt_pat, grp;
    logic [PW-1:0] ptr_q, ptr_nx;
    logic          last_grp, step, stb_q, mask_take;

    // R6: top input always closes a group
    assign eff_mask = {1'b1, mask_q[W-2:0]};

    gvi_lfsr_step #(.W(W), .TAPS(TAPS)) lfsr_i (
        .cur (base_q),
        .nxt (nxt_pat)
    );

    gvi_group_sel #(.W(W), .PW(PW)) sel_i (
        .bound (eff_mask),
        .ptr   (ptr_q),
        .grp   (grp),
        .nptr  (ptr_nx),
        .last  (last_grp)
    );

    assign step = en && !seed_ld;

    always_comb begin
        st_n      = st_q;
        mask_take = 1'b0;
        unique case (st_q)
            ST_BASE: begin
                if (seed_ld) begin
                    st_n      = ST_BASE;
                    mask_take = mask_ld;
                end else if (en) begin
                    st_n = last_grp ? ST_BASE : ST_MID;
                end else begin
                    mask_take = mask_ld;
                end
            end
            ST_MID: begin
                if (seed_ld)
                    st_n = ST_BASE;
                else if (en)
                    st_n = last_grp ? ST_BASE : ST_MID;
            end
            default: st_n = ST_BASE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_BASE;
        else
            st_q <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= SEED;
            vec_q  <= SEED;
            mask_q <= '1;
            ptr_q  <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (seed_ld) begin
                base_q <= seed_in;
                vec_q  <= seed_in;
                ptr_q  <= '0;
            end else if (step) begin
                vec_q <= (vec_q & ~grp) | (nxt_pat & grp);
                if (last_grp) begin
                    base_q <= nxt_pat;
                    ptr_q  <= '0;
                    stb_q  <= 1'b1;
                end else begin
                    ptr_q <= ptr_nx;
                end
            end
            if (mask_take)
                mask_q <= mask_in;
        end
    end

    assign vec_out  = vec_q;
    assign base_stb = stb_q;

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ld |=> (vec_q == $past(seed_in)) && (st_q == ST_BASE));
    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MID) |=> $stable(mask_q));
    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_ld) |=> $stable(vec_q) && $stable(ptr_q));
    // R9
    stb_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_stb |-> (vec_q == base_q) && (st_q == ST_BASE));
    // R4
    one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grp & eff_mask) == 1);
    // R5
    done_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_grp) |=> base_stb && (ptr_q == '0));
endmodule

// File: tb/gvi_pattern_gen_tb.sv
`timescale 1ns/1ps
module gvi_pattern_gen_tb_top;
    localparam int         W    = 8;
    localparam logic [7:0] TAPS = 8'hB8;
    localparam logic [7:0] SEED = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n, en, seed_ld, mask_ld;
    logic [7:0] seed_in, mask_in, vec_out;
    logic       base_stb;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_vec, m_base, m_mask;
    int         m_ptr;
    logic       m_stb;

    always #10 clk = ~clk;

    gvi_pattern_gen #(.W(W), .TAPS(TAPS), .SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_ld(seed_ld), .seed_in(seed_in),
        .mask_ld(mask_ld), .mask_in(mask_in), .vec_out(vec_out), .base_stb(base_stb)
    );

    function automatic logic [7:0] next_pat(input logic [7:0] x);
        return {x[6:0], ^(x & TAPS)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic sl, input logic [7:0] sv,
                         input logic ml, input logic [7:0] mv);
        en = e; seed_ld = sl; seed_in = sv; mask_ld = ml; mask_in = mv;
        @(negedge clk);
        en = 1'b0; seed_ld = 1'b0; mask_ld = 1'b0;
    endtask

    task automatic model_step();
        logic [7:0] nx;
        logic [7:0] eff;
        int i;
        nx  = next_pat(m_base);
        eff = m_mask | 8'h80;
        i   = m_ptr;
        while (1) begin
            m_vec[i] = nx[i];
            if (eff[i]) break;
            i++;
        end
        if (i == 7) begin
            m_base = nx; m_ptr = 0; m_stb = 1'b1;
        end else begin
            m_ptr = i + 1; m_stb = 1'b0;
        end
    endtask

    task automatic step_chk(input string req);
        model_step();
        drive(1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(vec_out == m_vec, req, vec_out, m_vec);
        chk(base_stb == m_stb, "R9", {7'd0, base_stb}, {7'd0, m_stb});
    endtask

    task automatic full_transition(input string req, output int n);
        n = 0;
        do begin
            step_chk(req);
            n++;
        end while (!m_stb && n < 16);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired R1..");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; en = 1'b0; seed_ld = 1'b0; mask_ld = 1'b0;
        seed_in = '0; mask_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(vec_out == SEED, "R1", vec_out, SEED);
        chk(base_stb == 1'b0, "R1", {7'd0, base_stb}, 8'd0);
        rst_n = 1'b1;
        m_vec = SEED; m_base = SEED; m_mask = 8'hFF; m_ptr = 0; m_stb = 1'b0;

        // R1 default mask: eight single-bit groups
        full_transition("R1", n);
        chk(n == 8, "R1", 8'(n), 8'd8);
        // R3 the completed base follows the tap formula
        chk(vec_out == next_pat(SEED), "R3", vec_out, next_pat(SEED));

        // sweep of every mask value (R4 R5 R6 R9)
        for (int m = 0; m < 256; m++) begin
            drive(1'b0, 1'b0, 8'h00, 1'b1, 8'(m));
            m_mask = 8'(m);
            chk(base_stb == 1'b0, "R9", {7'd0, base_stb}, 8'd0);
            chk(vec_out == m_vec, "R7", vec_out, m_vec);
            full_transition("R4", n);
            chk(n == $countones(8'(m) | 8'h80), "R5", 8'(n), 8'($countones(8'(m) | 8'h80)));
            chk(vec_out == m_base, "R5", vec_out, m_base);
        end

        // R7 and R8: mask load mid transition ignored, enable low freezes
        drive(1'b0, 1'b0, 8'h00, 1'b1, 8'h05);
        m_mask = 8'h05;
        step_chk("R4");
        drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hFF);
        chk(vec_out == m_vec, "R8", vec_out, m_vec);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
            chk(vec_out == m_vec, "R8", vec_out, m_vec);
        end
        full_transition("R7", n);
        chk(n == 2, "R7", 8'(n), 8'd2);
        full_transition("R7", n);
        chk(n == 3, "R7", 8'(n), 8'd3);
        // R7: mask load on a stepping clock in ST_BASE is ignored
        m_mask = 8'h05;
        model_step();
        drive(1'b1, 1'b0, 8'h00, 1'b1, 8'hFF);
        chk(vec_out == m_vec, "R7", vec_out, m_vec);
        full_transition("R7", n);
        chk(n == 2, "R7", 8'(n), 8'd2);

        // R2: seed load aborts a transition and beats enable
        step_chk("R4");
        drive(1'b1, 1'b1, 8'hC3, 1'b0, 8'h00);
        m_vec = 8'hC3; m_base = 8'hC3; m_ptr = 0;
        chk(vec_out == 8'hC3, "R2", vec_out, 8'hC3);
        chk(base_stb == 1'b0, "R2", {7'd0, base_stb}, 8'd0);
        full_transition("R2", n);
        chk(n == 3, "R2", 8'(n), 8'd3);
        chk(vec_out == next_pat(8'hC3), "R3", vec_out, next_pat(8'hC3));
        // R2 at idle with enable low
        drive(1'b0, 1'b1, 8'h3C, 1'b0, 8'h00);
        m_vec = 8'h3C; m_base = 8'h3C; m_ptr = 0;
        chk(vec_out == 8'h3C, "R2", vec_out, 8'h3C);
        full_transition("R2", n);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule